// File: doc/BRIEF.md
# Nibble Pattern Shift Engine

This block plays back pulse patterns on a small group of output pins. Software or an upstream sequencer writes 32-bit pattern words into a small internal FIFO. The engine takes one word at a time, cuts it into eight 4-bit slices and puts one slice on the four pins per tick, so each word fills eight ticks. A set bit in a slice raises the matching pin for that tick. At a 12.5 ns tick, four set slices in a row make a 50 ns pulse.

Each word carries a two-bit gap tag that says what happens after its eighth slice. The engine can go straight on to the next word. It can insert a counted pause, whose length comes from a delay input. It can also hold the pins low until the trigger input goes low. A run of all-zero words also works as a pause. If the FIFO runs dry, the pins rest at zero until a new word arrives.

Top module: `nib_shift_top`

## Requirements
- R1: While reset is asserted, and right after it, `pins` is 0 and `full` is 0.
- R2: A word is emitted least significant nibble first. Its slice k (bits 4k+3..4k) appears on `pins` during the k-th of eight consecutive ticks, and bit i of a slice drives `pins[i]`.
- R3: When a word's gap tag is 2'b00, the first slice of the next queued word follows its last slice on the very next tick, with no idle tick between them.
- R4: When no word is queued, `pins` holds 0. A word written into an empty FIFO during clock edge k shows its first slice on `pins` after edge k+1.
- R5: When a word's gap tag is 2'b01, the engine samples `delay_ticks` (N) on the tick that emits the word's last slice. It then drives N+1 ticks of 0 before the next word starts.
- R6: When a word's gap tag is 2'b10, the engine holds `pins` at 0 while the synchronized trigger is high. `trig` passes through SYNC_STAGES flops first. The next word starts on the tick after the first tick that sees the synchronized trigger low, so there is always at least one idle tick.
- R7: `full` is 1 exactly when DEPTH words are queued. A write while `full` is 1 is dropped and never appears on `pins`.
- R8: A gap tag of 2'b11 behaves like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe into the pattern FIFO |
| wr_word | input | WORD_W | Pattern word, eight 4-bit slices |
| wr_gap | input | 2 | Gap tag applied after this word |
| full | output | 1 | FIFO holds DEPTH words |
| delay_ticks | input | DLY_W | Countdown value used by tag 2'b01 |
| trig | input | 1 | Asynchronous trigger level |
| pins | output | LANES | Pattern outputs |

## Verification
The bench plays the pulse-pair words 0x11110000 and 0x00002222 back to back. Against these, a mistake in slice order or in the bit-to-pin mapping shows up as a pulse on the wrong pin or at the wrong time. The word 0x87654321, with a distinct value in every slice, exposes any swap or skip of slices. Countdown gaps are tried with delay values of 0, 3 and 5, which separates an off-by-one in the pause length from a wrong sampling moment. Trigger waits of several lengths, a FIFO filled past capacity while the engine is stalled, and tag 2'b11 words check the stall release, the dropped writes and the decoding of the spare tag.

// File: rtl/nib_shift_pkg.sv
package nib_shift_pkg;
   typedef enum logic [1:0] {
      GAP_NONE  = 2'b00,
      GAP_COUNT = 2'b01,
      GAP_TRIG  = 2'b10,
      GAP_SPARE = 2'b11
   } gap_e;

   typedef enum logic [1:0] {
      ST_LOAD  = 2'b00,
      ST_SHIFT = 2'b01,
      ST_COUNT = 2'b10,
      ST_WAIT  = 2'b11
   } eng_st_e;
endpackage

// File: rtl/nib_shift_fifo.sv
module nib_shift_fifo #(
   parameter int ENTRY_W = 34,
   parameter int DEPTH   = 4,
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] din,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head,
   output logic               empty,
   output logic               full,
   output logic [CNT_W-1:0]   level
);
   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wp_q, rp_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               do_push, do_pop;

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp_q];
   assign level   = cnt_q;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= nxt(wp_q);
         if (do_pop)  rp_q <= nxt(rp_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/nib_shift_sync.sv
module nib_shift_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic trig_s,
   output logic tick
);
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign trig_s = trig;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_q <= '0;
            end else begin
               sr_q[0] <= trig;
               for (int i = 1; i < SYNC_STAGES; i++) sr_q[i] <= sr_q[i-1];
            end
         end
         assign trig_s = sr_q[SYNC_STAGES-1];
      end

      if (TICK_DIV == 1) begin : g_fulltick
         assign tick = 1'b1;
      end else begin : g_divtick
         localparam int TW = $clog2(TICK_DIV);
         logic [TW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          div_q <= '0;
            else if (div_q == TW'(TICK_DIV - 1)) div_q <= '0;
            else                                 div_q <= div_q + TW'(1);
         end
         assign tick = (div_q == TW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/nib_shift_engine.sv
module nib_shift_engine
   import nib_shift_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int WORD_W = 32,
   parameter int DLY_W  = 16,
   localparam int SLICES = WORD_W / LANES,
   localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [WORD_W-1:0] head_word,
   input  logic [1:0]        head_gap,
   input  logic              empty,
   output logic              pop,
   input  logic [DLY_W-1:0]  delay_ticks,
   input  logic              trig_s,
   output logic [LANES-1:0]  pins,
   output eng_st_e           st,
   output logic [DLY_W-1:0]  cnt
);
   eng_st_e           st_q;
   logic [WORD_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;
   logic [1:0]        gap_q;
   logic [DLY_W-1:0]  cnt_q;
   logic [LANES-1:0]  pins_q;

   assign pop  = tick && (st_q == ST_LOAD) && !empty;
   assign pins = pins_q;
   assign st   = st_q;
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_LOAD;
         sh_q   <= '0;
         idx_q  <= '0;
         gap_q  <= '0;
         cnt_q  <= '0;
         pins_q <= '0;
      end else if (tick) begin
         case (st_q)
            ST_LOAD: begin
               if (!empty) begin
                  pins_q <= head_word[LANES-1:0];
                  sh_q   <= head_word >> LANES;
                  gap_q  <= head_gap;
                  idx_q  <= IDX_W'(1);
                  st_q   <= ST_SHIFT;
               end else begin
                  pins_q <= '0;
               end
            end
            ST_SHIFT: begin
               pins_q <= sh_q[LANES-1:0];
               sh_q   <= sh_q >> LANES;
               if (idx_q == IDX_W'(SLICES - 1)) begin
                  case (gap_e'(gap_q))
                     GAP_COUNT: begin
                        cnt_q <= delay_ticks;
                        st_q  <= ST_COUNT;
                     end
                     GAP_TRIG: st_q <= ST_WAIT;
                     default:  st_q <= ST_LOAD;
                  endcase
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
            ST_COUNT: begin
               pins_q <= '0;
               if (cnt_q == '0) st_q  <= ST_LOAD;
               else             cnt_q <= cnt_q - DLY_W'(1);
            end
            default: begin
               pins_q <= '0;
               if (!trig_s) st_q <= ST_LOAD;
            end
         endcase
      end
   end
endmodule

// File: rtl/nib_shift_top.sv
module nib_shift_top
   import nib_shift_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int WORD_W      = 32,
   parameter int DEPTH       = 4,
   parameter int DLY_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 1,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [1:0]        wr_gap,
   output logic              full,
   input  logic [DLY_W-1:0]  delay_ticks,
   input  logic              trig,
   output logic [LANES-1:0]  pins
);
   generate
      if (WORD_W % LANES != 0) begin : g_bad_split
         $error("WORD_W must be a multiple of LANES");
      end
      if (WORD_W / LANES < 2) begin : g_bad_slices
         $error("a word needs at least two slices");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [WORD_W+1:0] head;
   logic              empty, pop, tick, trig_s;
   logic [CNT_W-1:0]  level;
   eng_st_e           st;
   logic [DLY_W-1:0]  cnt;

   nib_shift_fifo #(.ENTRY_W(WORD_W + 2), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .din({wr_gap, wr_word}),
      .pop(pop), .head(head), .empty(empty), .full(full), .level(level)
   );

   nib_shift_sync #(.SYNC_STAGES(SYNC_STAGES), .TICK_DIV(TICK_DIV)) u_sync (
      .clk(clk), .rst_n(rst_n), .trig(trig), .trig_s(trig_s), .tick(tick)
   );

   nib_shift_engine #(.LANES(LANES), .WORD_W(WORD_W), .DLY_W(DLY_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .head_word(head[WORD_W-1:0]), .head_gap(head[WORD_W+1:WORD_W]),
      .empty(empty), .pop(pop), .delay_ticks(delay_ticks), .trig_s(trig_s),
      .pins(pins), .st(st), .cnt(cnt)
   );
endmodule

// File: rtl/nib_shift_chk.sv
module nib_shift_chk
   import nib_shift_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DEPTH = 4,
   parameter int DLY_W = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input eng_st_e          st,
   input logic [DLY_W-1:0] cnt,
   input logic [CNT_W-1:0] level,
   input logic             empty,
   input logic             trig_s,
   input logic             full,
   input logic [LANES-1:0] pins
);
   assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !(tick && st == ST_LOAD)) |=> $stable(level));

   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && st == ST_LOAD && empty) |=> (pins == '0));

   assert_count_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && st == ST_COUNT) |=> (pins == '0));

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && st == ST_COUNT && cnt != '0) |=>
         (st == ST_COUNT && cnt == $past(cnt) - DLY_W'(1)));

   assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && st == ST_WAIT && trig_s) |=> (st == ST_WAIT && pins == '0));
endmodule

bind nib_shift_top nib_shift_chk #(.LANES(LANES), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .st(st), .cnt(cnt), .level(level),
   .empty(empty), .trig_s(trig_s), .full(full), .pins(pins)
);

// File: tb/tb_nib_shift_top.sv
module tb_nib_shift_top;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_word = '0;
   logic [1:0]  wr_gap = '0;
   logic        full;
   logic [15:0] delay_ticks = '0;
   logic        trig = 1'b0;
   logic [3:0]  pins;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   nib_shift_top #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
      .wr_gap(wr_gap), .full(full), .delay_ticks(delay_ticks),
      .trig(trig), .pins(pins)
   );

   always #4 clk = ~clk;

   // behavioural reference: queue of {gap, word}, a slice counter and gap timers
   logic [33:0] q[$];
   int          m_mode;   // 0 ready, 1 emitting, 2 counting, 3 waiting
   int          m_k;
   logic [31:0] m_rest;
   logic [1:0]  m_gap;
   int          m_left;
   logic [3:0]  m_pins;
   bit          t1, t2;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_mode = 0; m_k = 0; m_rest = '0; m_gap = '0; m_left = 0;
         m_pins = '0; t1 = 0; t2 = 0;
      end else begin
         bit          was_full;
         logic [33:0] e;
         was_full = (q.size() == DEPTH);
         if (m_mode == 0) begin
            if (q.size() > 0) begin
               e = q.pop_front();
               m_pins = e[3:0];
               m_rest = e[31:0] >> 4;
               m_gap = e[33:32];
               m_k = 1;
               m_mode = 1;
            end else m_pins = '0;
         end else if (m_mode == 1) begin
            m_pins = m_rest[3:0];
            m_rest = m_rest >> 4;
            if (m_k == 7) begin
               if (m_gap == 2'b01) begin
                  m_left = int'(delay_ticks) + 1;
                  m_mode = 2;
               end else if (m_gap == 2'b10) m_mode = 3;
               else m_mode = 0;
            end else m_k++;
         end else if (m_mode == 2) begin
            m_pins = '0;
            m_left--;
            if (m_left == 0) m_mode = 0;
         end else begin
            m_pins = '0;
            if (!t2) m_mode = 0;
         end
         if (wr_en && !was_full) q.push_back({wr_gap, wr_word});
         t2 = t1;
         t1 = trig;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check({cur_req, " pins"}, 32'(pins), 32'(m_pins));
         check({cur_req, " full"}, 32'(full), 32'(q.size() == DEPTH));
      end
   end

   task automatic put(input logic [31:0] w, input logic [1:0] g);
      wr_en = 1'b1; wr_word = w; wr_gap = g;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         check("R1 pins in reset", 32'(pins), 32'h0);
         check("R1 full in reset", 32'(full), 32'h0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pins after reset", 32'(pins), 32'h0);

      // R2 R3: pulse pair, then a word with all slices distinct
      cur_req = "R2 R3";
      put(32'h1111_0000, 2'b00);
      put(32'h0000_2222, 2'b00);
      put(32'h8765_4321, 2'b00);
      idle(30);

      // R4: single word into empty FIFO, then idle
      cur_req = "R4";
      put(32'h0000_4444, 2'b00);
      idle(15);

      // R5: countdown gaps of 0, 5 and 3
      cur_req = "R5";
      delay_ticks = 16'd0;
      put(32'h0000_000F, 2'b01);
      put(32'h1000_0001, 2'b00);
      idle(20);
      delay_ticks = 16'd5;
      put(32'h2200_0022, 2'b01);
      put(32'h0000_0044, 2'b00);
      idle(25);
      delay_ticks = 16'd3;
      put(32'h3333_3333, 2'b01);
      put(32'h0000_0000, 2'b01);
      put(32'h8000_0008, 2'b00);
      idle(35);

      // R6: trigger wait, short and long
      cur_req = "R6";
      trig = 1'b1;
      put(32'h0000_8888, 2'b10);
      put(32'h0000_4444, 2'b00);
      idle(20);
      trig = 1'b0;
      idle(20);
      put(32'h0000_0011, 2'b10);
      put(32'h0000_0022, 2'b00);
      idle(20);

      // R7: fill past capacity while the engine stalls on the trigger
      cur_req = "R7";
      trig = 1'b1;
      put(32'h0000_0001, 2'b10);
      idle(12);
      for (int i = 0; i < DEPTH + 2; i++) put(32'h0000_0100 + 32'(i), 2'b00);
      check("R7 full when DEPTH words held", 32'(full), 32'h1);
      idle(5);
      trig = 1'b0;
      idle(60);
      check("R7 full clears after drain", 32'(full), 32'h0);

      // R8: spare tag runs straight on
      cur_req = "R8";
      put(32'hA5A5_A5A5, 2'b11);
      put(32'h5A5A_5A5A, 2'b11);
      put(32'h0000_0F0F, 2'b00);
      idle(40);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule